// File: doc/BRIEF.md
# Oversampling Manchester Receive Decoder

This block turns a Manchester-coded serial stream, already reduced to a single logic level and sampled at eight times the bit rate, back into NRZ data and a recovered bit clock. It rejects one-sample noise pulses and raises a carrier flag on the first qualified transition. It then spends a fixed number of bit cells acquiring phase before it delivers bits. It follows each mid-cell transition within plus or minus one sample. When a mid-cell transition fails to arrive, it treats the frame as ended, drops carrier, and runs the recovered clock for a fixed tail before parking it low. A loopback select replaces the line input with an internal encoder stream.

The core is a four-state machine. The states are S_IDLE (no activity), S_ACQ (carrier up, phase being acquired), S_LOCK (bits being delivered) and S_TAIL (carrier down, clock tail running). The transitions are:
- S_IDLE to S_ACQ on any filtered transition.
- S_ACQ to S_LOCK on the sixth in-window mid-cell transition.
- S_ACQ to S_IDLE when the window times out.
- S_LOCK to S_TAIL when the window times out.
- S_TAIL to S_IDLE after the last tail period.

S_ACQ and S_LOCK loop on themselves while mid-cell transitions keep arriving.

Top module: `mdec_rx`

## Requirements
- R1: After reset, carrier, rx_clk and rx_data are all low.
- R2: The selected input must hold a new level for two consecutive samples before it counts. A one-sample pulse on an idle line never raises carrier.
- R3: Carrier rises within four sample clocks of the first qualified transition after idle.
- R4: The first six bit cells of a frame are used for acquisition. No rx_clk rising edge occurs during them, and the first bit delivered is bit index 6.
- R5: A delivered bit equals the level after the mid-cell transition: low-to-high means 1, high-to-low means 0. Every delivered bit appears on rx_data before the rx_clk rising edge that marks it, and each bit after acquisition is delivered exactly once, in order.
- R6: rx_data does not change on a clock edge at which rx_clk rises.
- R7: A mid-cell transition is accepted 7 to 9 samples after the previous one, and the cell timing is realigned on it. Transitions earlier in the cell (cell boundaries) are ignored.
- R8: With no mid-cell transition for 9 samples, the frame ends. Carrier is still high when the last bit cell ends and is low within 12 samples after it.
- R9: After carrier falls at the end of a locked frame, rx_clk gives exactly five more rising edges, starting on the next sample clock, and then stays low while idle.
- R10: With loop_en high, loop_rx feeds the decoder, and activity on line_rx has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, eight times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_rx | input | 1 | Digitized receive line level |
| loop_rx | input | 1 | Internal encoder stream used in loopback |
| loop_en | input | 1 | High selects loop_rx instead of line_rx |
| carrier | output | 1 | High while a frame is being received |
| rx_clk | output | 1 | Recovered bit clock; bits are valid at its rising edge |
| rx_data | output | 1 | Recovered NRZ data |

## Verification
The decoder is fed the following frames:
- A frame ending in a one, so the line falls at the final cell boundary.
- A frame whose payload is all zeros and ends in a zero, which separates a decoder that reads the mid-cell level from one that reads the cell-boundary level.
- A frame with mid-cell transitions pushed one sample early and late, which shows whether the phase window realigns on every cell rather than counting from the first edge.
- A loopback frame with the line toggling every sample, and a line frame while loopback is selected, which together show which input is actually decoded.

Isolated one-sample pulses separate the two-sample qualifier from a plain edge detector. Counting clock edges after carrier falls fixes the tail length exactly.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    // Receive state of the decoder
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ACQ  = 2'd1,
        S_LOCK = 2'd2,
        S_TAIL = 2'd3
    } mdec_state_e;

endpackage

// File: rtl/mdec_squelch.sv
// Input selection and run-length qualifier: the level only follows the
// selected input after MIN_RUN identical consecutive samples.
module mdec_squelch #(
    parameter int MIN_RUN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_rx,
    input  logic loop_rx,
    input  logic loop_en,
    output logic level
);

    localparam int HW = MIN_RUN - 1;

    logic          raw;
    logic [HW-1:0] hist;
    logic          agree;

    assign raw   = loop_en ? loop_rx : line_rx;
    assign agree = (hist == {HW{raw}});

    generate
        if (HW == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= raw;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= {hist[HW-2:0], raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)     level <= 1'b0;
        else if (agree) level <= raw;
    end

endmodule

// File: rtl/mdec_edge.sv
// Flags a change of the qualified level since the previous sample.
module mdec_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic trans
);

    logic level_d;

    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign trans = level ^ level_d;

endmodule

// File: rtl/mdec_rx.sv
module mdec_rx
    import mdec_pkg::*;
#(
    parameter int OVS       = 8,
    parameter int JIT       = 1,
    parameter int MIN_RUN   = 2,
    parameter int LOCK_BITS = 6,
    parameter int TAIL_BITS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_rx,
    input  logic loop_rx,
    input  logic loop_en,
    output logic carrier,
    output logic rx_clk,
    output logic rx_data
);

    localparam int MID_LO = OVS - JIT;
    localparam int MID_HI = OVS + JIT;
    localparam int HALF   = OVS / 2;
    localparam int CNT_W  = $clog2(MID_HI + 1);
    localparam int NM_W   = $clog2(LOCK_BITS + 1);
    localparam int TL_W   = $clog2(TAIL_BITS + 1);

    localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_LO   = CNT_W'(MID_LO);
    localparam logic [CNT_W-1:0] C_HI   = CNT_W'(MID_HI);
    localparam logic [CNT_W-1:0] C_OVS  = CNT_W'(OVS);
    localparam logic [CNT_W-1:0] C_HALF = CNT_W'(HALF);
    localparam logic [NM_W-1:0]  N_LAST = NM_W'(LOCK_BITS - 1);
    localparam logic [TL_W-1:0]  T_LAST = TL_W'(TAIL_BITS - 1);

    mdec_state_e       state, state_nx;
    logic              level, trans;
    logic [CNT_W-1:0]  cnt;
    logic [NM_W-1:0]   nmid;
    logic [TL_W-1:0]   tcnt;
    logic              have_bit;
    logic              mid_hit, timeout, wrap;

    mdec_squelch #(.MIN_RUN(MIN_RUN)) u_sq (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_rx (line_rx),
        .loop_rx (loop_rx),
        .loop_en (loop_en),
        .level   (level)
    );

    mdec_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (level),
        .trans (trans)
    );

    // Window decisions on the samples-since-last-mid-edge count
    assign mid_hit = trans && (cnt >= C_LO);
    assign timeout = !mid_hit && (cnt >= C_HI);
    assign wrap    = (cnt == C_OVS);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (trans) state_nx = S_ACQ;
            S_ACQ: begin
                if (mid_hit && nmid == N_LAST) state_nx = S_LOCK;
                else if (timeout)              state_nx = S_IDLE;
            end
            S_LOCK: if (timeout) state_nx = S_TAIL;
            S_TAIL: if (wrap && tcnt == T_LAST) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Cell timing and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            nmid     <= '0;
            tcnt     <= '0;
            have_bit <= 1'b0;
            rx_data  <= 1'b0;
            rx_clk   <= 1'b0;
        end else begin
            rx_clk <= (((state == S_LOCK) && have_bit) || (state == S_TAIL))
                      && (cnt >= C_ONE) && (cnt <= C_HALF);
            unique case (state)
                S_IDLE: begin
                    cnt      <= trans ? C_ONE : '0;
                    nmid     <= NM_W'(1);
                    tcnt     <= '0;
                    have_bit <= 1'b0;
                end
                S_ACQ: begin
                    if (mid_hit) begin
                        cnt  <= C_ONE;
                        nmid <= nmid + NM_W'(1);
                    end else if (timeout) begin
                        cnt <= C_ONE;
                    end else begin
                        cnt <= cnt + C_ONE;
                    end
                end
                S_LOCK: begin
                    if (mid_hit) begin
                        cnt      <= C_ONE;
                        rx_data  <= level;
                        have_bit <= 1'b1;
                    end else if (timeout) begin
                        cnt <= C_ONE;
                    end else begin
                        cnt <= cnt + C_ONE;
                    end
                end
                S_TAIL: begin
                    have_bit <= 1'b0;
                    if (wrap) begin
                        cnt  <= C_ONE;
                        tcnt <= tcnt + TL_W'(1);
                    end else begin
                        cnt <= cnt + C_ONE;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign carrier = (state == S_ACQ) || (state == S_LOCK);

endmodule

// File: rtl/mdec_rx_checker.sv
module mdec_rx_checker
    import mdec_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        loop_en,
    input logic        loop_rx,
    input logic        carrier,
    input logic        rx_clk,
    input logic        rx_data,
    input mdec_state_e state
);

    // R6: data is settled before the recovered clock rises
    a_r6_data_before_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_clk) |-> $stable(rx_data));

    // R10: a quiet loopback stream keeps carrier down whatever the line does
    a_r10_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier && loop_en && !loop_rx
         && $past(loop_en && !loop_rx, 1)
         && $past(loop_en && !loop_rx, 2)
         && $past(loop_en && !loop_rx, 3)) |=> !carrier);

    // R9: the tail starts with a clock pulse on the following sample
    a_r9_tail_starts: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_LOCK && state == S_TAIL) |=> rx_clk);

    // R9: clock parked low while idle
    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !rx_clk);

    // R4: no recovered clock during acquisition
    a_r4_acq_no_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACQ) |-> !rx_clk);

endmodule

bind mdec_rx mdec_rx_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .loop_en (loop_en),
    .loop_rx (loop_rx),
    .carrier (carrier),
    .rx_clk  (rx_clk),
    .rx_data (rx_data),
    .state   (state)
);

// File: tb/mdec_rx_bench.sv
module mdec_rx_bench;

    localparam int LOCK = 6;
    localparam int TAIL = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_rx = 1'b0;
    logic loop_rx = 1'b0;
    logic loop_en = 1'b0;
    logic carrier, rx_clk, rx_data;

    int   vectors = 0, fails = 0;
    int   mon_checks = 0, mon_fails = 0;
    int   tail_rises = 0, carrier_cycles = 0;
    logic clk_prev = 1'b0;
    logic exp_q[$];

    always #10 clk = ~clk;

    mdec_rx u_mdec_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_rx (line_rx),
        .loop_rx (loop_rx),
        .loop_en (loop_en),
        .carrier (carrier),
        .rx_clk  (rx_clk),
        .rx_data (rx_data)
    );

    // Monitor: compares every recovered bit against the scoreboard (R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (carrier) carrier_cycles++;
            if (rx_clk && !clk_prev) begin
                if (carrier) begin
                    mon_checks++;
                    if (exp_q.size() == 0) begin
                        mon_fails++;
                        $display("FAIL R5 unexpected bit: actual=%0d expected=none", rx_data);
                    end else begin
                        logic e;
                        e = exp_q.pop_front();
                        if (rx_data !== e) begin
                            mon_fails++;
                            $display("FAIL R5 bit mismatch: actual=%0d expected=%0d", rx_data, e);
                        end
                    end
                end else begin
                    tail_rises++;
                end
            end
        end
        clk_prev = rx_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0: line frame; 1: loopback frame with line noise; 2: line frame while in loopback
    task automatic put(input logic v, input int mode);
        @(negedge clk);
        case (mode)
            0: begin loop_en = 1'b0; loop_rx = 1'b0; line_rx = v; end
            1: begin loop_en = 1'b1; loop_rx = v; line_rx = ~line_rx; end
            default: begin loop_en = 1'b1; loop_rx = 1'b0; line_rx = v; end
        endcase
    endtask

    function automatic int jpat(input int k);
        case (k % 4)
            1: return 1;
            3: return -1;
            default: return 0;
        endcase
    endfunction

    task automatic send_frame(input logic [63:0] bits, input int n, input bit jit, input int mode);
        int tail_base, car_base;
        tail_base = tail_rises;
        car_base  = carrier_cycles;
        for (int k = 0; k < n; k++) begin
            int j;
            j = jit ? jpat(k) : 0;
            if (mode != 2 && k >= LOCK) exp_q.push_back(bits[k]);
            for (int s = 0; s < 8; s++)
                put((s < 4 + j) ? ~bits[k] : bits[k], mode);
            if (mode != 2 && k == 1) chk(carrier === 1'b1, "R3 carrier up", carrier, 1);
            if (mode != 2 && k == LOCK - 1) chk(rx_clk === 1'b0 && tail_rises == tail_base,
                                                "R4 no clock in acquisition", rx_clk, 0);
        end
        if (mode != 2) begin
            @(negedge clk);
            chk(carrier === 1'b1, "R8 carrier held to end of last bit", carrier, 1);
            for (int i = 0; i < 12; i++) put(1'b0, mode);
            chk(carrier === 1'b0, "R8 carrier drop within 12 samples", carrier, 0);
            for (int i = 0; i < 60; i++) put(1'b0, mode);
            chk(tail_rises - tail_base == TAIL, "R9 tail edge count", tail_rises - tail_base, TAIL);
            chk(rx_clk === 1'b0, "R9 clock parked low", rx_clk, 0);
            chk(exp_q.size() == 0, "R5 all bits delivered", exp_q.size(), 0);
        end else begin
            for (int i = 0; i < 80; i++) put(1'b0, mode);
            chk(carrier_cycles == car_base, "R10 line ignored in loopback",
                carrier_cycles - car_base, 0);
            chk(tail_rises == tail_base, "R10 no clock in loopback", tail_rises - tail_base, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==",
                 vectors + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(carrier === 1'b0, "R1 carrier after reset", carrier, 0);
        chk(rx_clk === 1'b0, "R1 rx_clk after reset", rx_clk, 0);
        chk(rx_data === 1'b0, "R1 rx_data after reset", rx_data, 0);

        // R2: isolated one-sample pulses
        base = carrier_cycles;
        for (int p = 0; p < 10; p++) begin
            put(1'b1, 0);
            for (int i = 0; i < 5; i++) put(1'b0, 0);
        end
        repeat (10) put(1'b0, 0);
        chk(carrier_cycles == base, "R2 short pulses rejected", carrier_cycles - base, 0);

        // R5/R8/R9: mixed payload ending in a one
        send_frame(64'h0000_0000_00B4_3D55, 24, 1'b0, 0);
        // R5: zero payload ending in a zero
        send_frame(64'h0000_0000_0000_0055, 24, 1'b0, 0);
        // R7: mid-cell transitions moved by one sample
        send_frame(64'h0000_0000_C3A5_6955, 32, 1'b1, 0);
        // R10: loopback stream decoded while the line toggles
        send_frame(64'h0000_0000_0006_AD55, 20, 1'b0, 1);
        // R10: line frame ignored while loopback is selected
        send_frame(64'h0000_0000_00FF_0F55, 24, 1'b0, 2);

        $display("== %0d vectors applied, %0d miscompares ==",
                 vectors + mon_checks, fails + mon_fails);
        $finish;
    end

endmodule